// File: doc/BRIEF.md
# Receive Endpoint Packet Buffer Controller

This block holds the OUT-direction data of a single device endpoint. The bus-facing side streams packet bytes in with a write strobe and marks the end of each packet. The processor side reads the bytes of the oldest stored packet one at a time, sees that packet's length, and releases it by pulsing a clear. The release also sends a one-cycle acknowledge pulse toward the bus side.

The block holds either one or two packets. Two-packet operation is used only when the storage depth is at least twice the configured maximum packet size and the disable input is low. The ready and full flags have different meanings in the two modes. An accept output tells the bus side whether a new packet can be taken. A packet that starts while accept is low is dropped completely. An optional auto-release mode frees a maximum-size packet as soon as its last byte has been read.

Top module: `rx_ep_buf`

## Requirements
- R1: `dbl_mode_o` is high exactly when `dbl_dis_i` is low and DEPTH >= 2*`max_pkt_i` (with DEPTH=64: max 32 gives double, max 33 gives single).
- R2: In single mode, a completed packet raises both `rdy_o` and `full_o`, and `usb_accept_o` drops until the packet is released.
- R3: In double mode, the first stored packet raises `rdy_o` only. A second stored packet also raises `full_o` and drops `usb_accept_o`.
- R4: A packet whose first byte (or bare end marker) arrives while `usb_accept_o` is low is dropped whole. Flags, length and stored data are unchanged.
- R5: A `cpu_clr_i` pulse while `rdy_o` is high frees the oldest packet and discards any of its unread bytes. `ack_o` is high for the single following cycle. A clear with no packet stored has no effect.
- R6: Clearing while two packets are stored promotes the second one. `rdy_o` stays high, `full_o` falls, `cpu_cnt_o` takes the second packet's length, and `irq_o` pulses.
- R7: `irq_o` is a one-cycle pulse in the cycle after a packet becomes the oldest stored packet. It does not pulse when a second packet is queued behind an existing one.
- R8: With `auto_clr_i` high, reading the last byte of a packet whose length equals `max_pkt_i` frees that packet as if cleared. A shorter packet stays until it is cleared.
- R9: `cpu_cnt_o` is the byte length of the oldest stored packet, or 0 when none is stored. Zero-length packets are stored with length 0.
- R10: Bytes past `max_pkt_i` within one packet are not stored, so the length is capped at `max_pkt_i`.
- R11: `cpu_data_o` shows the next unread byte of the oldest packet, in arrival order. A `cpu_rd_i` pulse advances it, and reads past the packet length are ignored.
- R12: After reset: `rdy_o`=0, `full_o`=0, `usb_accept_o`=1, `cpu_cnt_o`=0, `irq_o`=0, `ack_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| max_pkt_i | input | CW | Maximum packet size in bytes (CW = log2(DEPTH)+1) |
| dbl_dis_i | input | 1 | Forces single-packet operation |
| auto_clr_i | input | 1 | Enables auto-release of maximum-size packets |
| usb_wr_i | input | 1 | Byte write strobe |
| usb_data_i | input | 8 | Byte written |
| usb_eop_i | input | 1 | End of packet; may coincide with the last byte |
| usb_accept_o | output | 1 | A new packet can be taken |
| cpu_rd_i | input | 1 | Consumes one byte of the oldest packet |
| cpu_clr_i | input | 1 | Releases the oldest packet |
| cpu_data_o | output | 8 | Next unread byte |
| cpu_cnt_o | output | CW | Length of the oldest packet |
| rdy_o | output | 1 | At least one packet stored |
| full_o | output | 1 | No free packet slot |
| irq_o | output | 1 | New oldest packet pulse |
| ack_o | output | 1 | Packet released pulse |
| dbl_mode_o | output | 1 | Two-packet operation active |

## Verification
The assertions check on every cycle that full never appears without ready, that a stored packet never lands when no slot is free, that interrupt and acknowledge pulses line up with the ready state, and that the read position and the write length stay within their packets. Other behaviours need the bench's scenarios: that a refused packet leaves the length and the data untouched, that promotion shows the second packet's bytes, that unread bytes are skipped on release, that auto-release waits for the final byte, and that the mode boundary falls where R1 places it.

// File: rtl/rx_ep_pkg.sv
package rx_ep_pkg;
  localparam int unsigned DW = 8;
  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/rx_ep_mem.sv
module rx_ep_mem #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  rx_ep_pkg::byte_t     wdata_i,
  input  logic [AW-1:0]        raddr_i,
  output rx_ep_pkg::byte_t     rdata_o
);
  rx_ep_pkg::byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rx_ep_wr.sv
module rx_ep_wr #(
  parameter int unsigned AW = 6,
  parameter int unsigned CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          eop_i,
  input  logic          accept_i,
  input  logic [CW-1:0] max_pkt_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic          push_o,
  output logic [CW-1:0] push_len_o
);
  logic          in_pkt_q, drop_q;
  logic [AW-1:0] wc_q;
  logic [CW-1:0] wlen_q;
  logic          start, drop, take;

  // admission is decided once, at the first event of a packet
  assign start       = (wr_i | eop_i) & ~in_pkt_q;
  assign drop        = start ? ~accept_i : drop_q;
  assign take        = wr_i & ~drop & (wlen_q < max_pkt_i);
  assign mem_we_o    = take;
  assign mem_waddr_o = wc_q + wlen_q[AW-1:0];
  assign push_o      = eop_i & ~drop;
  assign push_len_o  = wlen_q + CW'(take);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      wc_q     <= '0;
      wlen_q   <= '0;
    end else if (eop_i) begin
      in_pkt_q <= 1'b0;
      drop_q   <= 1'b0;
      wlen_q   <= '0;
      if (push_o) wc_q <= wc_q + push_len_o[AW-1:0];
    end else if (wr_i) begin
      in_pkt_q <= 1'b1;
      drop_q   <= drop;
      if (take) wlen_q <= wlen_q + 1'b1;
    end
  end

  // R10
  trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wlen_q <= max_pkt_i);
  // R4
  refuse_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pkt_q && drop_q) |-> !push_o);
endmodule

// File: rtl/rx_ep_q.sv
module rx_ep_q #(
  parameter int unsigned AW = 6,
  parameter int unsigned CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dbl_i,
  input  logic          auto_clr_i,
  input  logic [CW-1:0] max_pkt_i,
  input  logic          push_i,
  input  logic [CW-1:0] push_len_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic [AW-1:0] raddr_o,
  output logic          rdy_o,
  output logic          full_o,
  output logic          accept_o,
  output logic [CW-1:0] cnt_o,
  output logic          irq_o,
  output logic          ack_o
);
  logic [1:0]    npkt_q;
  logic [AW-1:0] hs_q;
  logic [CW-1:0] rd_cnt_q, len0_q, len1_q;
  logic          rd_ok, auto_pop, pop, new_head;

  assign rdy_o    = npkt_q != 2'd0;
  assign full_o   = dbl_i ? (npkt_q == 2'd2) : (npkt_q == 2'd1);
  assign accept_o = ~full_o;
  assign cnt_o    = rdy_o ? len0_q : '0;
  assign raddr_o  = hs_q + rd_cnt_q[AW-1:0];

  assign rd_ok    = rd_i & rdy_o & (rd_cnt_q < len0_q);
  assign auto_pop = auto_clr_i & rd_ok & ((rd_cnt_q + 1'b1) == len0_q) & (len0_q == max_pkt_i);
  assign pop      = rdy_o & (clr_i | auto_pop);
  assign new_head = (push_i & ((npkt_q == 2'd0) | (pop & (npkt_q == 2'd1))))
                  | (pop & (npkt_q == 2'd2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npkt_q   <= '0;
      hs_q     <= '0;
      rd_cnt_q <= '0;
      len0_q   <= '0;
      len1_q   <= '0;
      irq_o    <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      irq_o <= new_head;
      ack_o <= pop;
      unique case ({push_i, pop})
        2'b10: begin
          if (npkt_q == 2'd0) len0_q <= push_len_i;
          else                len1_q <= push_len_i;
          npkt_q <= npkt_q + 2'd1;
        end
        2'b01: begin
          len0_q <= len1_q;
          npkt_q <= npkt_q - 2'd1;
        end
        2'b11: begin
          if (npkt_q == 2'd1) len0_q <= push_len_i;
          else begin
            len0_q <= len1_q;
            len1_q <= push_len_i;
          end
        end
        default: ;
      endcase
      if (pop) begin
        hs_q     <= hs_q + len0_q[AW-1:0];
        rd_cnt_q <= '0;
      end else if (rd_ok) begin
        rd_cnt_q <= rd_cnt_q + 1'b1;
      end
    end
  end

  // R2
  full_needs_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> rdy_o);
  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R5
  ack_after_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(rdy_o));
  // R7
  irq_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rdy_o);
  // R11
  rd_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (rd_cnt_q <= len0_q));
endmodule

// File: rtl/rx_ep_buf.sv
module rx_ep_buf #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    max_pkt_i,
  input  logic             dbl_dis_i,
  input  logic             auto_clr_i,
  input  logic             usb_wr_i,
  input  logic [7:0]       usb_data_i,
  input  logic             usb_eop_i,
  output logic             usb_accept_o,
  input  logic             cpu_rd_i,
  input  logic             cpu_clr_i,
  output logic [7:0]       cpu_data_o,
  output logic [CW-1:0]    cpu_cnt_o,
  output logic             rdy_o,
  output logic             full_o,
  output logic             irq_o,
  output logic             ack_o,
  output logic             dbl_mode_o
);
  localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

  logic          mem_we, push;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] push_len;
  logic [CW:0]   twice_max;

  assign twice_max  = {max_pkt_i, 1'b0};
  assign dbl_mode_o = ~dbl_dis_i & (twice_max <= DEPTH_W);

  rx_ep_wr #(.AW(AW), .CW(CW)) u_wr (
    .clk_i, .rst_ni,
    .wr_i(usb_wr_i), .eop_i(usb_eop_i), .accept_i(usb_accept_o),
    .max_pkt_i, .mem_we_o(mem_we), .mem_waddr_o(waddr),
    .push_o(push), .push_len_o(push_len)
  );

  rx_ep_q #(.AW(AW), .CW(CW)) u_q (
    .clk_i, .rst_ni,
    .dbl_i(dbl_mode_o), .auto_clr_i, .max_pkt_i,
    .push_i(push), .push_len_i(push_len),
    .rd_i(cpu_rd_i), .clr_i(cpu_clr_i),
    .raddr_o(raddr), .rdy_o, .full_o, .accept_o(usb_accept_o),
    .cnt_o(cpu_cnt_o), .irq_o, .ack_o
  );

  rx_ep_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(waddr), .wdata_i(usb_data_i),
    .raddr_i(raddr), .rdata_o(cpu_data_o)
  );
endmodule

// File: tb/sim_rx_ep_buf.sv
`timescale 1ns/1ps
module sim_rx_ep_buf;
  localparam int CW = 7;
  localparam int NV = 13;
  // {op[1:0], arg[7:0], rdy, full, accept, cnt[6:0]}; op 1=send, 2=read, 3=clear
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 8'd5,  1'b1, 1'b0, 1'b1, 7'd5},   // R3 first packet
    {2'd1, 8'd16, 1'b1, 1'b1, 1'b0, 7'd5},   // R3 second sets full
    {2'd1, 8'd3,  1'b1, 1'b1, 1'b0, 7'd5},   // R4 refused
    {2'd3, 8'd0,  1'b1, 1'b0, 1'b1, 7'd16},  // R6 promote
    {2'd2, 8'd16, 1'b1, 1'b0, 1'b1, 7'd16},  // R8 no auto
    {2'd3, 8'd0,  1'b0, 1'b0, 1'b1, 7'd0},   // R5
    {2'd1, 8'd0,  1'b1, 1'b0, 1'b1, 7'd0},   // R9 zero length
    {2'd1, 8'd7,  1'b1, 1'b1, 1'b0, 7'd0},   // R3
    {2'd3, 8'd0,  1'b1, 1'b0, 1'b1, 7'd7},   // R6
    {2'd3, 8'd0,  1'b0, 1'b0, 1'b1, 7'd0},   // R5
    {2'd3, 8'd0,  1'b0, 1'b0, 1'b1, 7'd0},   // R5 clear when empty
    {2'd1, 8'd20, 1'b1, 1'b0, 1'b1, 7'd16},  // R10 truncated
    {2'd3, 8'd0,  1'b0, 1'b0, 1'b1, 7'd0}    // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] max_pkt = 7'd16;
  logic dbl_dis = 1'b0, auto_clr = 1'b0;
  logic usb_wr = 1'b0, usb_eop = 1'b0, cpu_rd = 1'b0, cpu_clr = 1'b0;
  logic [7:0] usb_data = '0, cpu_data;
  logic [CW-1:0] cpu_cnt;
  logic accept, rdy, full, irq, ack, dbl_mode;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  rx_ep_buf u0 (
    .clk_i(clk), .rst_ni(rst_n), .max_pkt_i(max_pkt), .dbl_dis_i(dbl_dis),
    .auto_clr_i(auto_clr), .usb_wr_i(usb_wr), .usb_data_i(usb_data),
    .usb_eop_i(usb_eop), .usb_accept_o(accept), .cpu_rd_i(cpu_rd),
    .cpu_clr_i(cpu_clr), .cpu_data_o(cpu_data), .cpu_cnt_o(cpu_cnt),
    .rdy_o(rdy), .full_o(full), .irq_o(irq), .ack_o(ack), .dbl_mode_o(dbl_mode)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int n, int base);
    if (n == 0) begin
      @(negedge clk); usb_eop = 1'b1;
    end else begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        usb_wr = 1'b1; usb_data = 8'(base + i); usb_eop = (i == n - 1);
      end
    end
    @(negedge clk); usb_wr = 1'b0; usb_eop = 1'b0;
  endtask

  task automatic rd_bytes(int n, int base, bit dat, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dat) chk(req, cpu_data, (base + i) & 8'hff);
      cpu_rd = 1'b1;
    end
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); cpu_clr = 1'b1;
    @(negedge clk); cpu_clr = 1'b0;
  endtask

  task automatic flags(string req, int r, int f, int a, int c);
    chk({req, " rdy"}, rdy, r);
    chk({req, " full"}, full, f);
    chk({req, " accept"}, accept, a);
    chk({req, " cnt"}, cpu_cnt, c);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R12
    flags("R12", 0, 0, 1, 0);
    chk("R12 irq", irq, 0);
    chk("R12 ack", ack, 0);
    chk("R1 dbl at 16", dbl_mode, 1);

    for (int v = 0; v < NV; v++) begin
      unique case (VEC[v][19:18])
        2'd1: send(int'(VEC[v][17:10]), v * 16);
        2'd2: rd_bytes(int'(VEC[v][17:10]), 0, 1'b0, "R11");
        default: clr();
      endcase
      flags($sformatf("vec%0d", v), VEC[v][9], VEC[v][8], VEC[v][7], int'(VEC[v][6:0]));
    end

    // R11 data order and reads past end
    send(4, 8'hA0);
    chk("R7 irq on first", irq, 1);
    rd_bytes(4, 8'hA0, 1'b1, "R11 data");
    rd_bytes(2, 0, 1'b0, "R11");
    chk("R11 overread cnt", cpu_cnt, 4);
    clr();
    chk("R5 ack", ack, 1);
    @(negedge clk);
    chk("R5 ack one cycle", ack, 0);

    // R5 unread bytes discarded, R6 promoted data
    send(3, 8'hB0);
    send(2, 8'hC0);
    chk("R7 no irq on queued", irq, 0);
    rd_bytes(1, 8'hB0, 1'b1, "R11 data");
    clr();
    chk("R6 irq", irq, 1);
    chk("R6 ack", ack, 1);
    rd_bytes(2, 8'hC0, 1'b1, "R5 R6 data");
    clr();
    // R4 refused data does not land
    send(2, 8'hD0);
    send(2, 8'hD8);
    send(5, 8'hE0);
    clr();
    flags("R4 after refuse", 1, 0, 1, 2);
    rd_bytes(2, 8'hD8, 1'b1, "R4 data");
    clr();

    // R2 single via disable bit
    dbl_dis = 1'b1;
    @(negedge clk);
    chk("R1 disable", dbl_mode, 0);
    send(4, 8'h10);
    flags("R2 single", 1, 1, 0, 4);
    send(2, 8'h20);
    flags("R4 single refuse", 1, 1, 0, 4);
    clr();
    flags("R2 released", 0, 0, 1, 0);

    // R1 size boundary
    dbl_dis = 1'b0; max_pkt = 7'd32;
    @(negedge clk);
    chk("R1 max 32", dbl_mode, 1);
    max_pkt = 7'd33;
    @(negedge clk);
    chk("R1 max 33", dbl_mode, 0);
    send(3, 8'h30);
    flags("R2 single by size", 1, 1, 0, 3);
    clr();

    // R8 auto-clear, double mode
    max_pkt = 7'd16; auto_clr = 1'b1;
    send(16, 8'h40);
    send(4, 8'h60);
    rd_bytes(16, 8'h40, 1'b1, "R8 data");
    flags("R8 auto promote", 1, 0, 1, 4);
    rd_bytes(4, 8'h60, 1'b1, "R8 data");
    flags("R8 short stays", 1, 0, 1, 4);
    clr();
    // R8 auto-clear, single mode
    dbl_dis = 1'b1;
    send(16, 8'h70);
    rd_bytes(15, 8'h70, 1'b1, "R8 data");
    flags("R8 before last", 1, 1, 0, 16);
    rd_bytes(1, 8'h7F, 1'b1, "R8 data");
    flags("R8 single auto", 0, 0, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule